// File: doc/BRIEF.md
# Pipelined Argmax/Argmin Selector

The selector takes sixteen unsigned 8-bit operands in parallel and names the one that wins. By default the winner is the largest operand. When the mode input is high, the winner is the smallest. The block returns the winning value and the 4-bit position of the input that carried it.

Internally it is a balanced binary tree of two-input compare-select cells with a register after every level, four levels in all. Each cell decides by looking at the borrow out of a subtraction. That decision steers a 2:1 multiplexer for the value and another for the position. Flipping the decision turns the cell from a maximum picker into a minimum picker.

The mode bit and a valid flag travel through the registers next to the data. A new operand set can therefore enter on every clock, with any mix of modes, and no stall is ever needed.

Top module: `argsel_top`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low at a rising edge, `res_valid` is low after that edge. After reset is released, `res_valid` stays low until a valid input set has had time to reach the output.
- R2: `res_valid` equals the `set_valid` value sampled four rising edges earlier. This holds from release of reset onward, and an idle input slot gives an idle output slot.
- R3: One operand set is accepted on every rising edge with `set_valid` high, with no stall. Back-to-back sets each produce their own result, in order.
- R4: With `pick_min` low when the set is sampled, `res_value` is the largest of the sixteen operands.
- R5: With `pick_min` high when the set is sampled, `res_value` is the smallest of the sixteen operands.
- R6: `res_index` is the position of an operand whose value equals `res_value`.
- R7: When several operands share the winning value, `res_index` is the lowest of their positions.
- R8: The mode is taken from the same edge as the operands. Alternating `pick_min` on consecutive sets yields, for each set, the result of its own mode.
- R9: Operand k occupies bits [8k+7:8k] of `set_data`. `res_index` reports k as an unsigned binary number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; clears the valid pipeline |
| set_valid | input | 1 | Marks `set_data` as an operand set to be judged |
| pick_min | input | 1 | 0 selects the largest operand, 1 the smallest |
| set_data | input | 128 | Sixteen unsigned 8-bit operands, operand k at bits [8k+7:8k] |
| res_valid | output | 1 | Result of the set sampled four edges earlier is present |
| res_value | output | 8 | Winning operand value |
| res_index | output | 4 | Position of the winning operand (lowest on a tie) |

## Verification
Two functions can act on the same cycle: the tie-break that prefers the lower position, and the per-set mode that travels with the data. The bench provokes this in two ways. It places equal extreme values at two positions in sets of both modes. It also streams sets back to back with the mode flipping on every one. Each result is judged against a linear scan, computed in the bench, that uses the set's own mode and keeps the first strict winner. A checker also relates every result to a delayed copy of its inputs. It tests that no operand beats the result and that no equal operand sits at a lower position.

// File: rtl/argsel_pkg.sv
// Package: shared sizing for the argmax/argmin selector.
// Assumes the operand count is a power of two, at least 2.
package argsel_pkg;
    parameter int unsigned ARG_N = 16;   // operands per set
    parameter int unsigned ARG_W = 8;    // bits per operand
endpackage

// File: rtl/argsel_cell.sv
// Module: argsel_cell
// Combinational compare-select cell. It subtracts b from a. The borrow says
// a < b; XOR with the mode turns that into "take b". A zero difference
// forces "take a", so ties keep the lower position.
// Assumes operand a always carries the lower position of the pair.
module argsel_cell #(
    parameter int unsigned W  = 8,
    parameter int unsigned IW = 4
) (
    input  logic [W-1:0]  a_val,
    input  logic [IW-1:0] a_idx,
    input  logic [W-1:0]  b_val,
    input  logic [IW-1:0] b_idx,
    input  logic          want_min,
    output logic [W-1:0]  y_val,
    output logic [IW-1:0] y_idx
);
    logic [W:0] diff;
    logic       borrow;
    logic       same;
    logic       take_b;

    // Subtract and derive borrow / equality.
    always_comb begin
        diff   = {1'b0, a_val} - {1'b0, b_val};
        borrow = diff[W];
        same   = ~borrow & ~(|diff[W-1:0]);
    end

    // Mode-inverted decision, suppressed on a tie.
    always_comb begin
        take_b = (borrow ^ want_min) & ~same;
    end

    // Steer value and position together.
    always_comb begin
        y_val = take_b ? b_val : a_val;
        y_idx = take_b ? b_idx : a_idx;
    end
endmodule

// File: rtl/argsel_level.sv
// Module: argsel_level
// One tree level: NI inputs feed NI/2 cells, and their results are
// registered. The valid flag and the mode bit are registered alongside.
// Only the valid flag is reset; data registers are not.
// Assumes NI is even and inputs are ordered by position.
module argsel_level #(
    parameter int unsigned NI = 16,
    parameter int unsigned W  = 8,
    parameter int unsigned IW = 4,
    localparam int unsigned NO = NI / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_min,
    input  logic [NI-1:0][W-1:0]   in_val,
    input  logic [NI-1:0][IW-1:0]  in_idx,
    output logic                   out_valid,
    output logic                   out_min,
    output logic [NO-1:0][W-1:0]   out_val,
    output logic [NO-1:0][IW-1:0]  out_idx
);
    logic [NO-1:0][W-1:0]  sel_val;
    logic [NO-1:0][IW-1:0] sel_idx;

    for (genvar j = 0; j < NO; j++) begin : g_cell
        argsel_cell #(.W(W), .IW(IW)) u_cell (
            .a_val    (in_val[2*j]),
            .a_idx    (in_idx[2*j]),
            .b_val    (in_val[2*j+1]),
            .b_idx    (in_idx[2*j+1]),
            .want_min (in_min),
            .y_val    (sel_val[j]),
            .y_idx    (sel_idx[j])
        );
    end

    // Valid flag register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Mode and winner registers, no reset needed.
    always_ff @(posedge clk) begin
        out_min <= in_min;
        out_val <= sel_val;
        out_idx <= sel_idx;
    end
endmodule

// File: rtl/argsel_top.sv
// Module: argsel_top
// Balanced pipelined tree of argsel_level stages. It reports the largest
// (pick_min=0) or smallest (pick_min=1) operand and its position, with
// latency log2(N). All interior nodes sit in one packed node array.
// Level l writes its outputs at offset N - (N >> l).
// Assumes N is a power of two.
module argsel_top #(
    parameter int unsigned N = argsel_pkg::ARG_N,
    parameter int unsigned W = argsel_pkg::ARG_W,
    localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned LVL = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_valid,
    input  logic           pick_min,
    input  logic [N*W-1:0] set_data,
    output logic           res_valid,
    output logic [W-1:0]   res_value,
    output logic [IW-1:0]  res_index
);
    logic [N-1:0][W-1:0]   lv0_val;
    logic [N-1:0][IW-1:0]  lv0_idx;
    logic [N-2:0][W-1:0]   node_val;
    logic [N-2:0][IW-1:0]  node_idx;
    logic [LVL-1:0]        stg_valid;
    logic [LVL-1:0]        stg_min;

    // Split the flat operand bus into positions.
    always_comb begin
        lv0_val = set_data;
    end

    for (genvar i = 0; i < N; i++) begin : g_base
        assign lv0_idx[i] = IW'(i);
    end

    for (genvar l = 0; l < LVL; l++) begin : g_lvl
        localparam int unsigned NI    = N >> l;
        localparam int unsigned NO    = NI / 2;
        localparam int unsigned O_OFF = N - (N >> l);
        if (l == 0) begin : g_first
            argsel_level #(.NI(NI), .W(W), .IW(IW)) u_level (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (set_valid),
                .in_min    (pick_min),
                .in_val    (lv0_val),
                .in_idx    (lv0_idx),
                .out_valid (stg_valid[l]),
                .out_min   (stg_min[l]),
                .out_val   (node_val[O_OFF +: NO]),
                .out_idx   (node_idx[O_OFF +: NO])
            );
        end else begin : g_next
            localparam int unsigned I_OFF = N - (N >> (l - 1));
            argsel_level #(.NI(NI), .W(W), .IW(IW)) u_level (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (stg_valid[l-1]),
                .in_min    (stg_min[l-1]),
                .in_val    (node_val[I_OFF +: NI]),
                .in_idx    (node_idx[I_OFF +: NI]),
                .out_valid (stg_valid[l]),
                .out_min   (stg_min[l]),
                .out_val   (node_val[O_OFF +: NO]),
                .out_idx   (node_idx[O_OFF +: NO])
            );
        end
    end

    // Drive the result ports from the tree root.
    always_comb begin
        res_valid = stg_valid[LVL-1];
        res_value = node_val[N-2];
        res_index = node_idx[N-2];
    end

    // The last mode flag has no consumer beyond the root.
    logic unused_mode;
    always_comb unused_mode = stg_min[LVL-1];
endmodule

// File: rtl/argsel_chk.sv
// Module: argsel_chk
// Checker bound to argsel_top. It keeps a delayed copy of each input set,
// its mode and its valid flag, log2(N) deep. It then judges every result
// against that copy.
module argsel_chk #(
    parameter int unsigned N = 16,
    parameter int unsigned W = 8,
    localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned LVL = $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           set_valid,
    input logic           pick_min,
    input logic [N*W-1:0] set_data,
    input logic           res_valid,
    input logic [W-1:0]   res_value,
    input logic [IW-1:0]  res_index
);
    logic [LVL-1:0]            dly_v;
    logic [LVL-1:0]            dly_m;
    logic [LVL-1:0][N*W-1:0]   dly_d;
    logic                      any_better;
    logic                      earlier_eq;
    logic                      at_index_ok;

    // Valid delay line, cleared by reset like the design's.
    always_ff @(posedge clk) begin
        if (!rst_n) dly_v <= '0;
        else        dly_v <= {dly_v[LVL-2:0], set_valid};
    end

    // Data and mode delay lines.
    always_ff @(posedge clk) begin
        dly_m <= {dly_m[LVL-2:0], pick_min};
        dly_d <= {dly_d[LVL-2:0], set_data};
    end

    // Scan the delayed set for a better or an earlier equal operand.
    always_comb begin
        any_better  = 1'b0;
        earlier_eq  = 1'b0;
        at_index_ok = (dly_d[LVL-1][res_index*W +: W] == res_value);
        for (int i = 0; i < N; i++) begin
            if (dly_m[LVL-1] ? (dly_d[LVL-1][i*W +: W] < res_value)
                             : (dly_d[LVL-1][i*W +: W] > res_value))
                any_better = 1'b1;
            if ((IW'(i) < res_index) && (dly_d[LVL-1][i*W +: W] == res_value))
                earlier_eq = 1'b1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == dly_v[LVL-1]);

    assert_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !dly_m[LVL-1]) |-> !any_better);

    assert_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && dly_m[LVL-1]) |-> !any_better);

    assert_index_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> at_index_ok);

    assert_lowest_tie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !earlier_eq);
endmodule

bind argsel_top argsel_chk #(.N(N), .W(W)) u_argsel_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (set_valid),
    .pick_min  (pick_min),
    .set_data  (set_data),
    .res_valid (res_valid),
    .res_value (res_value),
    .res_index (res_index)
);

// File: tb/test_argsel_top.sv
module test_argsel_top;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 16;
    localparam int W   = 8;
    localparam int LAT = 4;
    localparam int MAXQ = 64;

    typedef struct packed {
        logic         mode;
        logic [127:0] data;
        logic [7:0]   ev;
        logic [3:0]   ei;
    } vec_t;

    // Hand-worked vectors: mode, operands (operand k at bits 8k+7:8k), value, index.
    localparam vec_t TBL [9] = '{
        '{1'b0, 128'h00000000000000000000000000000000, 8'h00, 4'd0},   // R7 all equal
        '{1'b0, 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF, 8'hFF, 4'd0},   // R7
        '{1'b1, 128'h55555555555555555555555555555555, 8'h55, 4'd0},   // R5 R7
        '{1'b0, 128'h0F0E0D0C0B0A09080706050403020100, 8'h0F, 4'd15},  // R4 R9
        '{1'b1, 128'h0F0E0D0C0B0A09080706050403020100, 8'h00, 4'd0},   // R5 R8
        '{1'b0, 128'h00000000000000000000800000000000, 8'h80, 4'd5},   // R4 R9
        '{1'b1, 128'hFFFFFF01FFFF01FFFFFFFFFFFFFFFFFF, 8'h01, 4'd9},   // R5 R7
        '{1'b0, 128'h10C810101010101010101010C8101010, 8'hC8, 4'd3},   // R4 R7
        '{1'b1, 128'h007F7F7F7F7F7F7F7F7F7F7F7F7F7F7F, 8'h00, 4'd15}   // R5 R9
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           set_valid;
    logic           pick_min;
    logic [N*W-1:0] set_data;
    logic           res_valid;
    logic [W-1:0]   res_value;
    logic [3:0]     res_index;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic           q_vld  [MAXQ];
    logic           q_mode [MAXQ];
    logic [N*W-1:0] q_data [MAXQ];
    logic [7:0]     q_ev   [MAXQ];
    logic [3:0]     q_ei   [MAXQ];
    int             q_len;
    logic [31:0]    lfsr = 32'h1ACE_B00C;

    argsel_top i_argsel_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (set_valid),
        .pick_min  (pick_min),
        .set_data  (set_data),
        .res_valid (res_valid),
        .res_value (res_value),
        .res_index (res_index)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: first strict winner in position order.
    task automatic ref_pick(input logic [N*W-1:0] d, input logic m,
                            output logic [7:0] v, output logic [3:0] ix);
        v = d[7:0];
        ix = 4'd0;
        for (int k = 1; k < N; k++) begin
            if (m ? (d[k*W +: W] < v) : (d[k*W +: W] > v)) begin
                v  = d[k*W +: W];
                ix = 4'(k);
            end
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Drive the queued sets back to back and judge each after LAT edges.
    task automatic run_queue(input string tag);
        for (int t = 0; t < q_len + LAT; t++) begin
            @(negedge clk);
            if (t >= LAT) begin
                check(res_valid == q_vld[t-LAT], {tag, " R2 valid"}, int'(res_valid), int'(q_vld[t-LAT]));
                if (q_vld[t-LAT]) begin
                    check(res_value == q_ev[t-LAT],
                          q_mode[t-LAT] ? {tag, " R5 value"} : {tag, " R4 value"},
                          int'(res_value), int'(q_ev[t-LAT]));
                    check(res_index == q_ei[t-LAT], {tag, " R6 index"},
                          int'(res_index), int'(q_ei[t-LAT]));
                end
            end
            if (t < q_len) begin
                set_valid = q_vld[t];
                pick_min  = q_mode[t];
                set_data  = q_data[t];
            end else begin
                set_valid = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        rst_n = 1'b0;
        set_valid = 1'b0;
        pick_min = 1'b0;
        set_data = '0;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 reset state", int'(res_valid), 0);
        rst_n = 1'b1;

        // Table section: all hand-worked sets back to back (R3).
        q_len = 9;
        for (int k = 0; k < 9; k++) begin
            q_vld[k]  = 1'b1;
            q_mode[k] = TBL[k].mode;
            q_data[k] = TBL[k].data;
            q_ev[k]   = TBL[k].ev;
            q_ei[k]   = TBL[k].ei;
        end
        run_queue("table");

        // Streaming section: alternating mode every set (R8), bubbles (R2),
        // narrow value range to force ties (R7).
        q_len = 48;
        for (int k = 0; k < 48; k++) begin
            q_vld[k]  = (k % 7) != 6;
            q_mode[k] = k[0];
            for (int p = 0; p < N; p++) begin
                lfsr = next_rand(lfsr);
                q_data[k][p*W +: W] = (k < 24) ? {5'b0, lfsr[2:0]} : lfsr[7:0];
            end
            ref_pick(q_data[k], q_mode[k], q_ev[k], q_ei[k]);
        end
        run_queue("stream R3 R7 R8");

        // Reset during traffic: R1.
        @(negedge clk);
        set_valid = 1'b1;
        pick_min = 1'b0;
        set_data = TBL[3].data;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 reset mid-flight", int'(res_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        set_valid = 1'b0;
        for (int c = 0; c < LAT + 1; c++) begin
            @(negedge clk);
            check(res_valid == 1'b0, "R1 flushed after reset", int'(res_valid), 0);
        end

        // Single set after reset, exact latency (R2, R9).
        set_valid = 1'b1;
        pick_min = 1'b0;
        set_data = TBL[5].data;
        @(negedge clk);
        set_valid = 1'b0;
        for (int c = 1; c < LAT; c++) begin
            check(res_valid == 1'b0, "R2 not early", int'(res_valid), 0);
            @(negedge clk);
        end
        check(res_valid == 1'b1, "R2 arrives", int'(res_valid), 1);
        check(res_index == 4'd5, "R9 position", int'(res_index), 5);
        @(negedge clk);
        check(res_valid == 1'b0, "R2 single pulse", int'(res_valid), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule